// File: doc/BRIEF.md
# Receive Descriptor Ring Scatter Engine

This block takes one already-filtered frame, presented as a byte stream, and stores it in host memory. Host software supplies a ring of 16-byte receive descriptors. Each descriptor holds a buffer address, a control word and a count word. For each frame the engine checks that the host has handed the current descriptor over. It then spreads the bytes across as many chained buffers as the frame needs and writes the status and the byte count back into the descriptors. The first descriptor is handed back to the host last, and a one-cycle receive interrupt pulse follows.

The byte stream uses valid/ready with explicit start and end markers. A byte is transferred in a cycle where `in_valid` and `in_ready` are both high. `in_ready` drops while a memory request is pending, so the source must hold `in_data`, `in_sop` and `in_eop` stable until the byte is taken. Memory traffic uses a plain request/acknowledge pair. A request stays asserted, with its address, enables and data unchanged, until the one-cycle `mem_ack`. `mem_rdata` is taken in the acknowledge cycle. The ring base, ring length and layout select are sampled live, so they should only change while `busy` is low.

Top module: `rx_ring_scatter`

## Requirements
- R1: Descriptor n of the ring sits at byte address ring_base + 16*n, and its control word is at offset 4. The position advances by one for every descriptor the engine consumes. It returns to 0 when position+1 reaches `ring_len`.
- R2: A frame whose start byte arrives while `ring_base` is 0, `rx_en` is low, or the current control word has bit 31 clear is discarded in full. The engine issues no memory write, pulses `rx_drop` for one cycle and leaves the position unchanged.
- R3: A buffer holds (-ctrl[11:0]) mod 4096 bytes. Frame bytes are written in order from the buffer address, one byte per write. Each write uses a one-hot `mem_be` selected by address bits 1:0 and carries the byte in all four lanes. A capacity of zero takes no bytes.
- R4: At most 2048 bytes of a frame are stored. Further bytes are accepted and dropped, and the stored count is used for the message count.
- R5: When a buffer is full and the frame is not finished, the engine reads the next control word. If its bit 31 is clear, the current control word gets bits 30, 27 and 24 set, the rest of the frame is dropped, and no count word is written.
- R6: Every consumed descriptor other than the first has its control word written back with bit 31 cleared. The last one also gets bit 24. The last descriptor's count word is written with `mem_be`=0011: bits 11:0 hold stored bytes + 4 and bits 15:12 are zero.
- R7: The first descriptor's control word is the final write of a frame. It carries bit 31 cleared and bit 25 set, plus bit 24 if that descriptor was also the last. `rx_irq` pulses for one cycle right after it.
- R8: With `desc_swap`=0 the buffer address is word 0 (offset 0) and the count word is word 2 (offset 8). With `desc_swap`=1 the two are exchanged.
- R9: A request holds `mem_addr`, `mem_we` and its data stable until acknowledged, and only one is outstanding. The writes of a frame come in this order: buffer bytes and intermediate control words in chain order, then the last control word and count, then the first control word.
- R10: `in_ready` is low whenever a memory request is pending. Bytes with `in_sop` low arriving between frames are consumed and have no effect on memory or position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable level |
| ring_base | input | ADDR_W | Byte address of descriptor 0 |
| ring_len | input | POS_W+1 | Number of descriptors in the ring (1..RING_MAX) |
| desc_swap | input | 1 | Descriptor layout select (R8) |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Stream byte accepted |
| in_data | input | 8 | Stream byte |
| in_sop | input | 1 | First byte of a frame |
| in_eop | input | 1 | Last byte of a frame |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Byte address |
| mem_be | output | 4 | Byte lane enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Request completed |
| rx_irq | output | 1 | One-cycle receive interrupt pulse |
| rx_drop | output | 1 | One-cycle pulse for a refused frame |
| busy | output | 1 | Engine is handling a frame |
| ring_pos | output | POS_W | Current ring position |

## Verification
The hardest paths to reach are the ring running dry in the middle of a chain, and a buffer error on the very first descriptor, where the error flags must merge into the final hand-back write rather than a separate one. The bench builds descriptor rings in its memory model with chosen ownership gaps and capacities, including a zero-capacity buffer and one that exactly fits the frame. It sends frames long enough to overrun them. The memory model varies its acknowledge latency, and a scoreboard compares every write against an order-exact expectation derived from the ring contents.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam int CTL_OWN  = 31;
  localparam int CTL_ERR  = 30;
  localparam int CTL_BUFF = 27;
  localparam int CTL_STP  = 25;
  localparam int CTL_ENP  = 24;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_OWN, S_RD_BUF, S_FILL, S_WR_BYTE,
    S_CHK_NEXT, S_WR_CUR, S_WR_CNT, S_WR_FIRST, S_DISCARD
  } rxs_state_e;

  typedef enum logic [1:0] {
    AFT_CNT, AFT_BUF, AFT_FIRST
  } rxs_after_e;
endpackage

// File: rtl/rxs_ring_ptr.sv
module rxs_ring_ptr #(
  parameter int ADDR_W = 32,
  parameter int POS_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic [POS_W:0]    ring_len,
  input  logic              advance,
  output logic [POS_W-1:0]  pos,
  output logic [ADDR_W-1:0] desc_addr
);
  localparam int DESC_SHIFT = 4;

  logic [POS_W-1:0] pos_q;
  logic [POS_W:0]   pos_inc;

  assign pos_inc   = {1'b0, pos_q} + 1'b1;
  assign pos       = pos_q;
  assign desc_addr = ring_base + (ADDR_W'(pos_q) << DESC_SHIFT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
    end else if (advance) begin
      pos_q <= (pos_inc >= ring_len) ? '0 : pos_inc[POS_W-1:0];
    end
  end

  AST_RING_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && (pos_inc == ring_len)) |=> (pos_q == '0)); // R1
  AST_RING_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && (pos_inc < ring_len)) |=> (pos_q == $past(pos_q) + 1'b1)); // R1
  AST_RING_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(pos_q)); // R1
endmodule

// File: rtl/rxs_desc_fmt.sv
module rxs_desc_fmt #(
  parameter int CNT_W = 12
) (
  input  logic             swap,
  input  logic [CNT_W-1:0] ctl_len,
  output logic [3:0]       buf_off,
  output logic [3:0]       cnt_off,
  output logic [CNT_W-1:0] cap
);
  localparam logic [3:0] OFF_W0 = 4'd0;
  localparam logic [3:0] OFF_W2 = 4'd8;

  always_comb begin
    buf_off = swap ? OFF_W2 : OFF_W0;
    cnt_off = swap ? OFF_W0 : OFF_W2;
    cap     = (~ctl_len) + 1'b1;
  end
endmodule

// File: rtl/rx_ring_scatter.sv
module rx_ring_scatter
  import rxs_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int RING_MAX  = 512,
  parameter int MAX_FRAME = 2048,
  parameter int POS_W     = $clog2(RING_MAX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic [POS_W:0]    ring_len,
  input  logic              desc_swap,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              in_sop,
  input  logic              in_eop,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ack,
  output logic              rx_irq,
  output logic              rx_drop,
  output logic              busy,
  output logic [POS_W-1:0]  ring_pos
);
  localparam int CNT_W   = 12;
  localparam int LEN_W   = $clog2(MAX_FRAME + 1);
  localparam int FCS_LEN = 4;
  localparam logic [31:0] OWN_M = 32'h1 << CTL_OWN;
  localparam logic [31:0] ENP_M = 32'h1 << CTL_ENP;
  localparam logic [31:0] STP_M = 32'h1 << CTL_STP;
  localparam logic [31:0] ERR_M = (32'h1 << CTL_ERR) | (32'h1 << CTL_BUFF) | ENP_M;

  rxs_state_e        state;
  rxs_after_e        after_q;
  logic [31:0]       cur_w1, first_w1, nxt_w1;
  logic [ADDR_W-1:0] cur_addr, first_addr, buf_addr;
  logic [CNT_W-1:0]  buf_cnt;
  logic [LEN_W-1:0]  tot_cnt;
  logic              is_first, last_q, eop_seen;
  logic [7:0]        byte_q;

  logic              advance;
  logic [ADDR_W-1:0] desc_addr;
  logic [3:0]        buf_off, cnt_off;
  logic [CNT_W-1:0]  cap;
  logic              frame_end, buf_full, refuse;
  logic [CNT_W-1:0]  msg_cnt;
  logic [ADDR_W-1:0] byte_addr;

  rxs_ring_ptr #(.ADDR_W(ADDR_W), .POS_W(POS_W)) ptr_i (
    .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .ring_len(ring_len),
    .advance(advance), .pos(ring_pos), .desc_addr(desc_addr)
  );

  rxs_desc_fmt #(.CNT_W(CNT_W)) fmt_i (
    .swap(desc_swap), .ctl_len(cur_w1[CNT_W-1:0]),
    .buf_off(buf_off), .cnt_off(cnt_off), .cap(cap)
  );

  assign frame_end = last_q || (({1'b0, tot_cnt} + 1'b1) == (LEN_W+1)'(MAX_FRAME));
  assign buf_full  = ({1'b0, buf_cnt} + 1'b1) == {1'b0, cap};
  assign refuse    = (ring_base == '0) || !rx_en;
  assign msg_cnt   = CNT_W'(tot_cnt) + CNT_W'(FCS_LEN);
  assign byte_addr = buf_addr + ADDR_W'(buf_cnt);
  assign busy      = (state != S_IDLE);
  assign advance   = mem_ack && (((state == S_RD_BUF) && (cap == '0)) ||
                                 ((state == S_WR_BYTE) && (frame_end || buf_full)));

  always_comb begin
    in_ready = (state == S_FILL) || (state == S_DISCARD) || ((state == S_IDLE) && !in_sop);
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_be    = 4'hF;
    mem_wdata = '0;
    case (state)
      S_RD_OWN:   begin mem_req = 1'b1; mem_addr = cur_addr + ADDR_W'(4); end
      S_RD_BUF:   begin mem_req = 1'b1; mem_addr = cur_addr + ADDR_W'(buf_off); end
      S_CHK_NEXT: begin mem_req = 1'b1; mem_addr = desc_addr + ADDR_W'(4); end
      S_WR_BYTE: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = byte_addr;
        mem_be    = 4'b0001 << byte_addr[1:0];
        mem_wdata = {4{byte_q}};
      end
      S_WR_CUR: begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_addr = cur_addr + ADDR_W'(4); mem_wdata = cur_w1;
      end
      S_WR_CNT: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_be = 4'b0011;
        mem_addr = cur_addr + ADDR_W'(cnt_off); mem_wdata = 32'(msg_cnt);
      end
      S_WR_FIRST: begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_addr = first_addr + ADDR_W'(4);
        mem_wdata = (first_w1 & ~OWN_M) | STP_M;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      after_q    <= AFT_CNT;
      cur_w1     <= '0;
      first_w1   <= '0;
      nxt_w1     <= '0;
      cur_addr   <= '0;
      first_addr <= '0;
      buf_addr   <= '0;
      buf_cnt    <= '0;
      tot_cnt    <= '0;
      is_first   <= 1'b0;
      last_q     <= 1'b0;
      eop_seen   <= 1'b0;
      byte_q     <= '0;
      rx_irq     <= 1'b0;
      rx_drop    <= 1'b0;
    end else begin
      rx_irq  <= 1'b0;
      rx_drop <= 1'b0;
      case (state)
        S_IDLE: if (in_valid && in_sop) begin
          if (refuse) begin
            rx_drop <= 1'b1;
            state   <= S_DISCARD;
          end else begin
            cur_addr   <= desc_addr;
            first_addr <= desc_addr;
            state      <= S_RD_OWN;
          end
        end
        S_RD_OWN: if (mem_ack) begin
          if (!mem_rdata[CTL_OWN]) begin
            rx_drop <= 1'b1;
            state   <= S_DISCARD;
          end else begin
            cur_w1   <= mem_rdata;
            first_w1 <= mem_rdata;
            is_first <= 1'b1;
            tot_cnt  <= '0;
            eop_seen <= 1'b0;
            state    <= S_RD_BUF;
          end
        end
        S_RD_BUF: if (mem_ack) begin
          buf_addr <= mem_rdata[ADDR_W-1:0];
          buf_cnt  <= '0;
          state    <= (cap == '0) ? S_CHK_NEXT : S_FILL;
        end
        S_FILL: if (in_valid) begin
          byte_q   <= in_data;
          last_q   <= in_eop;
          eop_seen <= in_eop;
          state    <= S_WR_BYTE;
        end
        S_WR_BYTE: if (mem_ack) begin
          buf_cnt <= buf_cnt + 1'b1;
          tot_cnt <= tot_cnt + 1'b1;
          if (frame_end) begin
            if (is_first) begin
              first_w1 <= first_w1 | ENP_M;
              state    <= S_WR_CNT;
            end else begin
              cur_w1  <= (cur_w1 & ~OWN_M) | ENP_M;
              after_q <= AFT_CNT;
              state   <= S_WR_CUR;
            end
          end else if (buf_full) begin
            state <= S_CHK_NEXT;
          end else begin
            state <= S_FILL;
          end
        end
        S_CHK_NEXT: if (mem_ack) begin
          if (mem_rdata[CTL_OWN]) begin
            if (is_first) begin
              cur_w1   <= mem_rdata;
              cur_addr <= desc_addr;
              is_first <= 1'b0;
              state    <= S_RD_BUF;
            end else begin
              nxt_w1  <= mem_rdata;
              cur_w1  <= cur_w1 & ~OWN_M;
              after_q <= AFT_BUF;
              state   <= S_WR_CUR;
            end
          end else if (is_first) begin
            first_w1 <= first_w1 | ERR_M;
            state    <= S_WR_FIRST;
          end else begin
            cur_w1  <= (cur_w1 & ~OWN_M) | ERR_M;
            after_q <= AFT_FIRST;
            state   <= S_WR_CUR;
          end
        end
        S_WR_CUR: if (mem_ack) begin
          case (after_q)
            AFT_CNT:   state <= S_WR_CNT;
            AFT_FIRST: state <= S_WR_FIRST;
            default: begin
              cur_w1   <= nxt_w1;
              cur_addr <= desc_addr;
              state    <= S_RD_BUF;
            end
          endcase
        end
        S_WR_CNT: if (mem_ack) state <= S_WR_FIRST;
        S_WR_FIRST: if (mem_ack) begin
          rx_irq <= 1'b1;
          state  <= eop_seen ? S_IDLE : S_DISCARD;
        end
        S_DISCARD: if (in_valid && in_eop) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R9
  AST_NO_IN_DURING_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !in_ready); // R10
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |=> !rx_irq); // R7
  AST_REFUSE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == S_IDLE) && in_valid && in_sop && refuse) |=> (rx_drop && !mem_req)); // R2
  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WR_BYTE) |-> (buf_cnt < cap)); // R3
  AST_TRUNC_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    tot_cnt <= LEN_W'(MAX_FRAME)); // R4
endmodule

// File: tb/rx_ring_scatter_tb_top.sv
`timescale 1ns/1ps
module rx_ring_scatter_tb_top;
  localparam int AW = 32;
  localparam int PW = 9;
  localparam logic [31:0] BASE = 32'h100;
  localparam logic [31:0] OWN_M = 32'h8000_0000;
  localparam logic [31:0] STP_M = 32'h0200_0000;
  localparam logic [31:0] ENP_M = 32'h0100_0000;
  localparam logic [31:0] EBE_M = 32'h4900_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_en = 1'b0, desc_swap = 1'b0;
  logic [AW-1:0] ring_base = BASE;
  logic [PW:0] ring_len = 10'd4;
  logic in_valid = 1'b0, in_ready, in_sop = 1'b0, in_eop = 1'b0;
  logic [7:0] in_data = '0;
  logic mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [3:0] mem_be;
  logic [31:0] mem_wdata, mem_rdata;
  logic rx_irq, rx_drop, busy;
  logic [PW-1:0] ring_pos;

  always #2.5 clk = ~clk;

  rx_ring_scatter dut_i (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .ring_base(ring_base), .ring_len(ring_len),
    .desc_swap(desc_swap), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .rx_irq(rx_irq), .rx_drop(rx_drop), .busy(busy), .ring_pos(ring_pos)
  );

  int checks = 0, errs = 0, irq_n = 0, drop_n = 0, cyc = 0;
  logic [31:0] mem [0:4095];
  logic [31:0] q_addr[$], q_data[$];
  logic [3:0]  q_be[$];
  int lat_cnt = 0, lat_sel = 0;

  bit d_own [0:7];
  int d_cap [0:7];
  logic [31:0] d_buf [0:7], d_w1 [0:7];
  int exp_pos = 0;
  int seed = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
  endtask

  // memory model and write scoreboard monitor
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
    end else if (mem_req) begin
      if (lat_cnt >= lat_sel) begin
        mem_ack <= 1'b1;
        lat_cnt <= 0;
        lat_sel <= (lat_sel + 1) % 3;
        if (mem_we) begin
          logic [31:0] m, ea, ed;
          logic [3:0] eb;
          for (int b = 0; b < 4; b++)
            if (mem_be[b]) mem[mem_addr[13:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
          if (q_addr.size() == 0) begin
            chk(1'b0, "R9 unexpected write", mem_addr, 32'hFFFF_FFFF);
          end else begin
            ea = q_addr.pop_front(); eb = q_be.pop_front(); ed = q_data.pop_front();
            m = {{8{eb[3]}}, {8{eb[2]}}, {8{eb[1]}}, {8{eb[0]}}};
            chk(mem_addr == ea, "R9 write address", mem_addr, ea);
            chk(mem_be == eb, "R3 write enables", {28'b0, mem_be}, {28'b0, eb});
            chk((mem_wdata & m) == (ed & m), "R6 write data", mem_wdata & m, ed & m);
          end
        end else begin
          mem_rdata <= mem[mem_addr[13:2]];
        end
      end else begin
        lat_cnt <= lat_cnt + 1;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (rx_irq) irq_n++;
    if (rx_drop) drop_n++;
    if (cyc == 150000) begin
      chk(1'b0, "watchdog", cyc, 0);
      summary();
      $finish;
    end
  end

  task automatic push(input logic [31:0] a, input logic [3:0] be, input logic [31:0] d);
    q_addr.push_back(a); q_be.push_back(be); q_data.push_back(d);
  endtask

  task automatic set_desc(input int i, input bit own, input int cap, input logic [31:0] bufa);
    logic [31:0] w1, a;
    w1 = (own ? OWN_M : 32'h0) | 32'h0000_F000 | (32'(-cap) & 32'hFFF);
    a = BASE + 32'(16 * i);
    mem[a[13:2] + 1] = w1;
    mem[a[13:2] + (desc_swap ? 2 : 0)] = bufa;
    mem[a[13:2] + (desc_swap ? 0 : 2)] = 32'hABCD_0000;
    d_own[i] = own; d_cap[i] = cap; d_buf[i] = bufa; d_w1[i] = w1;
  endtask

  function automatic logic [7:0] pat(input int j);
    return 8'((seed + j * 7) & 255);
  endfunction

  // reference: expected writes of one frame, derived from R1..R8
  task automatic model_frame(input int n, output bit ok);
    int stored, tot, cur, nxt, k, cap;
    bit first;
    logic [31:0] fw1, faddr, ca, ba;
    ok = 0;
    if (!d_own[exp_pos]) return;
    ok = 1;
    stored = (n > 2048) ? 2048 : n;
    tot = 0; first = 1; cur = exp_pos;
    fw1 = d_w1[cur]; faddr = BASE + 32'(16 * cur);
    while (1) begin
      cap = d_cap[cur];
      k = (cap < stored - tot) ? cap : stored - tot;
      for (int i = 0; i < k; i++) begin
        ba = d_buf[cur] + 32'(i);
        push(ba, 4'b0001 << ba[1:0], {4{pat(tot + i)}});
      end
      tot += k;
      ca = BASE + 32'(16 * cur);
      nxt = (cur + 1) % int'(ring_len);
      exp_pos = nxt;
      if (tot == stored) begin
        if (first) fw1 |= ENP_M;
        else push(ca + 4, 4'hF, (d_w1[cur] & ~OWN_M) | ENP_M);
        push(ca + (desc_swap ? 32'd0 : 32'd8), 4'b0011, 32'(stored + 4));
        break;
      end
      if (!d_own[nxt]) begin
        if (first) fw1 |= EBE_M;
        else push(ca + 4, 4'hF, (d_w1[cur] & ~OWN_M) | EBE_M);
        break;
      end
      if (!first) push(ca + 4, 4'hF, d_w1[cur] & ~OWN_M);
      cur = nxt; first = 0;
    end
    push(faddr + 4, 4'hF, (fw1 & ~OWN_M) | STP_M);
  endtask

  task automatic send_byte(input logic [7:0] d, input bit s, input bit e);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_sop = s; in_eop = e;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
  endtask

  task automatic run_frame(input int n, input string req);
    bit ok;
    int i0, d0;
    ok = 0;
    i0 = irq_n; d0 = drop_n;
    if (rx_en && ring_base != 0) model_frame(n, ok);
    for (int j = 0; j < n; j++) send_byte(pat(j), j == 0, j == n - 1);
    repeat (3) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(q_addr.size() == 0, {req, " all expected writes seen"}, q_addr.size(), 0);
    chk(irq_n - i0 == int'(ok), {req, " R7 irq pulses"}, irq_n - i0, int'(ok));
    chk(drop_n - d0 == int'(!ok), {req, " R2 drop pulses"}, drop_n - d0, int'(!ok));
    chk(int'(ring_pos) == exp_pos, {req, " R1 ring position"}, ring_pos, exp_pos);
    q_addr.delete(); q_be.delete(); q_data.delete();
    seed += 13;
  endtask

  task automatic ring_all(input int cap);
    for (int i = 0; i < 4; i++) set_desc(i, 1'b1, cap, 32'h1000 + 32'(i * 512) + 32'(i & 1));
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && mem_req == 1'b0, "reset idle R9", {busy, mem_req}, 0);
    chk(rx_irq == 1'b0 && rx_drop == 1'b0, "reset pulses R7", {rx_irq, rx_drop}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ring_pos == 0, "reset position R1", ring_pos, 0);
    rx_en = 1'b1;

    // R10: stray bytes between frames have no effect
    ring_all(64);
    send_byte(8'h55, 1'b0, 1'b0);
    send_byte(8'h66, 1'b0, 1'b1);
    repeat (4) @(negedge clk);
    chk(busy == 1'b0 && ring_pos == 0, "R10 stray bytes ignored", ring_pos, 0);

    // R3 R8: single-buffer frame, normal layout
    ring_all(64);
    run_frame(10, "R3 single");
    // R6 R8: chain of three buffers in swapped layout, ends with wrap
    desc_swap = 1'b1;
    ring_all(40);
    run_frame(100, "R6 R8 chain swapped");
    // R1 wrap already at 0 now; exact fill in normal layout
    desc_swap = 1'b0;
    ring_all(40);
    run_frame(40, "R3 exact fill");
    // R5 buffer error on a later descriptor (pos 1,2 owned, 3 not)
    ring_all(30);
    set_desc(3, 1'b0, 30, 32'h1600);
    run_frame(100, "R5 chain error");
    // R5 buffer error on the first descriptor (pos 3 owned, 0 not)
    ring_all(20);
    set_desc(0, 1'b0, 20, 32'h1000);
    run_frame(50, "R5 first error");
    // R2 refused: OWN clear at pos 0
    run_frame(8, "R2 not owned");
    // R2 refused: receiver disabled
    ring_all(64);
    rx_en = 1'b0;
    run_frame(8, "R2 disabled");
    rx_en = 1'b1;
    // R2 refused: ring base zero
    ring_base = '0;
    run_frame(8, "R2 base zero");
    ring_base = BASE;
    // R3 zero capacity buffer in the middle of a chain
    ring_all(16);
    set_desc(1, 1'b1, 0, 32'h1200);
    run_frame(20, "R3 zero capacity");
    // R4 truncation at 2048 bytes, pos 3
    ring_all(64);
    set_desc(3, 1'b1, 2100, 32'h2001);
    run_frame(2100, "R4 truncation");
    // R1 ring length 2 wraps after two descriptors
    ring_len = 10'd2;
    ring_all(32);
    run_frame(60, "R1 short ring");

    summary();
    $finish;
  end
endmodule